// File: doc/BRIEF.md
# Memory-Mapped SPI Host With Signature Unlock

This block lets a 16-bit host bus drive a memory card over SPI through a few word registers that sit inside a ROM address window. Until software writes a key word to a signature register, the window acts as plain ROM: reads return the ROM data and writes do nothing. Once the block is unlocked, the same addresses reach the SPI pins.

Software has two ways to move data. In the manual mode it drives chip select, the serial clock and the data-out line through register writes, and it reads the data-in line from a status register. In the automatic mode, one write of a byte starts an 8-bit exchange in SPI mode 0. A divided system clock paces that exchange, and the received byte can then be read in two placements. The host bus uses a request/acknowledge handshake. The block withholds the acknowledge for register accesses that arrive while an exchange is running.

Top module: `spi_rom_host`

## Requirements
- R1: After reset the block is locked, and spiCs, spiSck and spiMosi are all low.
- R2: A write of 0xC1AD to byte address 0x41FFE0 unlocks the block. A write of 0x0000 there locks it again. Any other value written there leaves the lock state unchanged.
- R3: While the block is locked, and for any address outside 0x41FFD0 to 0x41FFE3, a read returns romData and is acknowledged in the cycle of the request. Writes to window registers while locked change no SPI pin. When unlocked, window addresses that are not readable registers also read as romData.
- R4: When unlocked, a write to 0x41FFD8 sets spiCs from data bit 15 (1 = card selected) and the manual clock level from data bit 14. spiSck follows that manual level while no exchange runs.
- R5: When unlocked, a read of 0x41FFD0 returns the present spiMiso level in bit 13 and zero in all other bits.
- R6: When unlocked, a write to 0x41FFDA puts data bit 15 on spiMosi.
- R7: When unlocked, a write to 0x41FFDC starts an exchange of data bits 7:0, most significant bit first. spiMosi shows bit 7 from the next cycle on. spiSck then gives 8 pulses, each phase lasting HALF_DIV clocks, and spiMosi changes only just after a falling edge. After the exchange spiMosi keeps bit 0.
- R8: spiMiso is sampled at each rising spiSck edge, first bit most significant. After the exchange, 0x41FFD2 reads the byte in bits 7:0 with the upper bits zero, and 0x41FFD4 reads it in bits 15:8 with the lower bits zero. The byte stays unchanged until the next exchange ends.
- R9: While an exchange runs, every access to the unlocked window is held off with hostAck low, including signature writes. It completes in the first cycle after the exchange ends (16*HALF_DIV cycles after the start).
- R10: When an exchange ends, spiSck returns low and the manual clock level is cleared, even if it was high before the start.
- R11: An exchange does not change spiCs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Host access request, held until acknowledged |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Byte address of the access |
| hostWdata | input | 16 | Write data word |
| romData | input | 16 | Data from the ROM behind the window |
| spiMiso | input | 1 | Serial data from the card |
| hostAck | output | 1 | Access completes at the clock edge where hostReq and hostAck are both high |
| hostRdata | output | 16 | Read data, valid while hostAck is high on a read |
| spiCs | output | 1 | Card select, active high |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the card |

## Verification
The assertions assume that the host keeps hostReq and its address and data steady until hostAck is seen, and that hostReq does not change except away from the clock edge. They also assume spiMiso is a level that the bench changes only between edges. The stimulus drives every bus field and spiMiso on the falling clock edge, and it drops a request only after the edge that completed it. A behavioural model in the bench checks the pins, the acknowledge and the read data on every cycle. The model follows the register rules and the exchange timing in cycle counts.

// File: rtl/spi_rom_host_pkg.sv
package spi_rom_host_pkg;

  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  // byte offsets from the window base
  localparam logic [4:0] OFF_STAT = 5'h00;
  localparam logic [4:0] OFF_RX   = 5'h02;
  localparam logic [4:0] OFF_RXHI = 5'h04;
  localparam logic [4:0] OFF_CTRL = 5'h08;
  localparam logic [4:0] OFF_TXB  = 5'h0A;
  localparam logic [4:0] OFF_TXSH = 5'h0C;
  localparam logic [4:0] OFF_KEY  = 5'h10;
  localparam int         WIN_BYTES = 20;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 16'hC1AD;
  localparam logic [DATA_W-1:0] LOCK_KEY   = 16'h0000;

  typedef enum logic [1:0] {RD_ROM, RD_STAT, RD_RX, RD_RXHI} rdSel_e;

  typedef struct packed {
    logic   unlocked;
    logic   wrCtrl;
    logic   wrTxBit;
    logic   startXfer;
    logic   riseTick;
    logic   fallTick;
    logic   lastFall;
    logic   busy;
    logic   engSck;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/spi_rom_host_ctrl.sv
module spi_rom_host_ctrl
  import spi_rom_host_pkg::*;
#(
  parameter int                ADDR_W   = 23,
  parameter logic [ADDR_W-1:0] WIN_BASE = 23'h41FFD0,
  parameter int                HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostAck,
  output ctlStrobe_t        str
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [ADDR_W-1:0] offFull;
  logic [4:0]        offWord;
  logic              inWin, active, fire, regWr;
  logic              unlocked, busy, engSck;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              tick;

  assign offFull = hostAddr - WIN_BASE;
  assign inWin   = offFull < ADDR_W'(WIN_BYTES);
  assign offWord = {offFull[4:1], 1'b0};
  assign active  = hostReq && inWin && unlocked;
  assign hostAck = hostReq && !(active && busy);
  assign fire    = hostReq && hostAck;
  assign regWr   = fire && hostWe && active;
  assign tick    = busy && (divCnt == DIV_LAST);

  always_comb begin
    str           = '0;
    str.unlocked  = unlocked;
    str.wrCtrl    = regWr && (offWord == OFF_CTRL);
    str.wrTxBit   = regWr && (offWord == OFF_TXB);
    str.startXfer = regWr && (offWord == OFF_TXSH);
    str.riseTick  = tick && !engSck;
    str.fallTick  = tick && engSck;
    str.lastFall  = tick && engSck && (bitCnt == BIT_W'(BYTE_W - 1));
    str.busy      = busy;
    str.engSck    = engSck;
    str.rdSel     = RD_ROM;
    if (active && !hostWe) begin
      case (offWord)
        OFF_STAT: str.rdSel = RD_STAT;
        OFF_RX:   str.rdSel = RD_RX;
        OFF_RXHI: str.rdSel = RD_RXHI;
        default:  str.rdSel = RD_ROM;
      endcase
    end
  end

  // signature register: reachable while locked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked <= 1'b0;
    end else if (fire && hostWe && inWin && offWord == OFF_KEY) begin
      if (hostWdata == UNLOCK_KEY)    unlocked <= 1'b1;
      else if (hostWdata == LOCK_KEY) unlocked <= 1'b0;
    end
  end

  // divider and bit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      engSck <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (str.startXfer) begin
      busy   <= 1'b1;
      engSck <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        engSck <= !engSck;
        if (engSck) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == BIT_W'(BYTE_W - 1)) busy <= 1'b0;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // R9: a sequencer start never lands on a running exchange
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    busy && !str.lastFall |=> busy);

endmodule

// File: rtl/spi_rom_host_dp.sv
module spi_rom_host_dp
  import spi_rom_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        str,
  input  logic [1:0]        ctrlBits,
  input  logic [BYTE_W-1:0] txByte,
  input  logic [DATA_W-1:0] romData,
  input  logic              spiMiso,
  output logic [DATA_W-1:0] hostRdata,
  output logic              spiCs,
  output logic              spiSck,
  output logic              spiMosi
);

  logic              csBit, sckBit, mosiBit, sampBit;
  logic [BYTE_W-1:0] shiftReg, rxByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csBit    <= 1'b0;
      sckBit   <= 1'b0;
      mosiBit  <= 1'b0;
      sampBit  <= 1'b0;
      shiftReg <= '0;
      rxByte   <= '0;
    end else begin
      if (str.wrCtrl) begin
        csBit  <= ctrlBits[1];
        sckBit <= ctrlBits[0];
      end
      if (str.wrTxBit) mosiBit <= ctrlBits[1];
      if (str.startXfer) begin
        shiftReg <= txByte;
        mosiBit  <= txByte[BYTE_W-1];
      end
      if (str.riseTick) sampBit <= spiMiso;
      if (str.fallTick) begin
        shiftReg <= {shiftReg[BYTE_W-2:0], sampBit};
        if (!str.lastFall) mosiBit <= shiftReg[BYTE_W-2];
      end
      if (str.lastFall) begin
        rxByte <= {shiftReg[BYTE_W-2:0], sampBit};
        sckBit <= 1'b0;
      end
    end
  end

  always_comb begin
    case (str.rdSel)
      RD_STAT: hostRdata = {2'b00, spiMiso, 13'b0};
      RD_RX:   hostRdata = {8'h00, rxByte};
      RD_RXHI: hostRdata = {rxByte, 8'h00};
      default: hostRdata = romData;
    endcase
  end

  assign spiCs   = csBit;
  assign spiSck  = str.busy ? str.engSck : sckBit;
  assign spiMosi = mosiBit;

  // R8: received byte only moves on the closing edge of an exchange
  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !str.lastFall |=> $stable(rxByte));

endmodule

// File: rtl/spi_rom_host.sv
module spi_rom_host
  import spi_rom_host_pkg::*;
#(
  parameter int                ADDR_W   = 23,
  parameter logic [ADDR_W-1:0] WIN_BASE = 23'h41FFD0,
  parameter int                HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [15:0]       hostWdata,
  input  logic [15:0]       romData,
  input  logic              spiMiso,
  output logic              hostAck,
  output logic [15:0]       hostRdata,
  output logic              spiCs,
  output logic              spiSck,
  output logic              spiMosi
);

  ctlStrobe_t str;

  spi_rom_host_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .HALF_DIV(HALF_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostAck(hostAck), .str(str)
  );

  spi_rom_host_dp u_dp (
    .clk(clk), .rstN(rstN), .str(str),
    .ctrlBits(hostWdata[15:14]), .txByte(hostWdata[7:0]),
    .romData(romData), .spiMiso(spiMiso), .hostRdata(hostRdata),
    .spiCs(spiCs), .spiSck(spiSck), .spiMosi(spiMosi)
  );

  // R10: the clock pin is low once an exchange finishes
  a_r10_sck_low_on_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(str.busy) |-> !spiSck);

  // R7: data out holds steady while the clock is high during an exchange
  a_r7_mosi_hold_high: assert property (@(posedge clk) disable iff (!rstN)
    (str.busy && spiSck) |-> $stable(spiMosi));

  // R11: select is untouched across an exchange
  a_r11_cs_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (str.busy && $past(str.busy)) |-> $stable(spiCs));

  // R3: a locked block cannot move the select pin
  a_r3_locked_cs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(str.unlocked) |-> $stable(spiCs));

endmodule

// File: tb/tb_spi_rom_host.sv
module tb_spi_rom_host;

  localparam int HD = 2;
  localparam logic [22:0] BASE = 23'h41FFD0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWe = 1'b0;
  logic [22:0] hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] romData;
  logic        spiMiso = 1'b0;
  logic        hostAck;
  logic [15:0] hostRdata;
  logic        spiCs, spiSck, spiMosi;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  assign romData = hostAddr[15:0] ^ 16'h5A5A;

  spi_rom_host #(.ADDR_W(23), .WIN_BASE(BASE), .HALF_DIV(HD)) dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .romData(romData),
    .spiMiso(spiMiso), .hostAck(hostAck), .hostRdata(hostRdata),
    .spiCs(spiCs), .spiSck(spiSck), .spiMosi(spiMosi)
  );

  always #5 clk = ~clk;

  // card stand-in: pseudo-random data-in level, changed on falling clk
  logic [7:0] lfsr = 8'h01;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    spiMiso = lfsr[0];
  end

  // ---------------- behavioural reference ----------------
  bit       mUnl = 0, mCs = 0, mSck = 0, mMosi = 0, mBusy = 0;
  int       k = 0;
  logic [7:0] mTx = '0, mAcc = '0, mRx = '0;

  function automatic int offOf(logic [22:0] a);
    return int'(a) - int'(BASE);
  endfunction

  function automatic bit inWin(logic [22:0] a);
    return offOf(a) >= 0 && offOf(a) < 20;
  endfunction

  function automatic int wordOff(logic [22:0] a);
    return offOf(a) & ~1;
  endfunction

  function automatic bit expAck();
    return hostReq && !(inWin(hostAddr) && mUnl && mBusy);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mUnl = 0; mCs = 0; mSck = 0; mMosi = 0; mBusy = 0; k = 0;
      mTx = '0; mAcc = '0; mRx = '0;
    end else begin
      bit ack;
      bit act;
      ack = expAck();
      act = hostReq && inWin(hostAddr) && mUnl;
      if (mBusy) begin
        k++;
        if (k % (2*HD) == HD) mAcc = {mAcc[6:0], spiMiso};
        if (k == 16*HD) begin
          mBusy = 0; mRx = mAcc; mSck = 0; mMosi = mTx[0];
        end
      end
      if (ack && hostWe) begin
        if (inWin(hostAddr) && wordOff(hostAddr) == 'h10) begin
          if (hostWdata == 16'hC1AD) mUnl = 1;
          else if (hostWdata == 16'h0000) mUnl = 0;
        end
        if (act) begin
          case (wordOff(hostAddr))
            'h08: begin mCs = hostWdata[15]; mSck = hostWdata[14]; end
            'h0A: mMosi = hostWdata[15];
            'h0C: begin mBusy = 1; k = 0; mTx = hostWdata[7:0]; mMosi = hostWdata[7]; end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edges
  always begin
    @(negedge clk);
    #3;
    if (!done) begin
      bit eSck, eMosi;
      string tSck, tMosi, tCs, tRd;
      eSck  = mBusy ? bit'((k / HD) % 2) : mSck;
      eMosi = mBusy ? mTx[7 - k / (2*HD)] : mMosi;
      tSck  = !rstN ? "R1" : (mBusy ? "R7" : "R4_R10");
      tMosi = !rstN ? "R1" : (mBusy ? "R7" : "R6");
      tCs   = !rstN ? "R1" : (mBusy ? "R11" : "R4");
      chk(tCs, "spiCs", 16'(spiCs), 16'(mCs));
      chk(tSck, "spiSck", 16'(spiSck), 16'(eSck));
      chk(tMosi, "spiMosi", 16'(spiMosi), 16'(eMosi));
      chk("R9", "hostAck", 16'(hostAck), 16'(expAck()));
      if (hostReq && !hostWe && hostAck) begin
        logic [15:0] eRd;
        eRd = romData; tRd = "R3";
        if (inWin(hostAddr) && mUnl) begin
          case (wordOff(hostAddr))
            'h00: begin eRd = {2'b00, spiMiso, 13'b0}; tRd = "R5"; end
            'h02: begin eRd = {8'h00, mRx}; tRd = "R8"; end
            'h04: begin eRd = {mRx, 8'h00}; tRd = "R8"; end
            default: ;
          endcase
        end
        chk(tRd, "hostRdata", hostRdata, eRd);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic acc(input bit we, input logic [22:0] a, input logic [15:0] d,
                     output logic [15:0] rd);
    @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostAddr = a; hostWdata = d;
    forever begin
      #4;
      if (hostAck) begin rd = hostRdata; break; end
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    hostReq = 1'b0; hostWe = 1'b0;
  endtask

  task automatic wr(input logic [22:0] a, input logic [15:0] d);
    logic [15:0] junk;
    acc(1'b1, a, d, junk);
  endtask

  task automatic rdw(input logic [22:0] a, output logic [15:0] rd);
    acc(1'b0, a, 16'h0, rd);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nFail++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3: locked window behaves as ROM
    rdw(BASE + 23'h0, v);
    rdw(BASE + 23'h2, v);
    rdw(BASE + 23'h4, v);
    wr(BASE + 23'h8, 16'hC000);
    wr(BASE + 23'hA, 16'h8000);
    wr(BASE + 23'hC, 16'h00FF);
    repeat (4) @(negedge clk);

    // R2: wrong key keeps the lock, right key opens it
    wr(BASE + 23'h10, 16'h1234);
    rdw(BASE + 23'h0, v);
    chk("R2", "status after wrong key", v, (BASE[15:0]) ^ 16'h5A5A);
    wr(BASE + 23'h10, 16'hC1AD);
    rdw(BASE + 23'h0, v);
    chk("R2", "status bits clear after unlock", v & 16'hDFFF, 16'h0000);

    // R4, R5, R6: manual pin control
    wr(BASE + 23'h8, 16'h8000);
    wr(BASE + 23'h8, 16'hC000);
    wr(BASE + 23'h8, 16'h8000);
    for (int i = 0; i < 4; i++) rdw(BASE + 23'h0, v);
    wr(BASE + 23'hA, 16'h8000);
    wr(BASE + 23'hA, 16'h7FFF);

    // bit-banged byte
    for (int i = 0; i < 8; i++) begin
      logic [15:0] bitv;
      bitv = (16'h005A << (8 + i)) & 16'h8000;
      rdw(BASE + 23'h0, v);
      wr(BASE + 23'h8, 16'hC000);
      wr(BASE + 23'h8, 16'h8000);
      wr(BASE + 23'hA, bitv);
    end

    // R10: manual clock high before an exchange, R9 stalled readback
    wr(BASE + 23'h8, 16'hC000);
    wr(BASE + 23'hC, 16'h00A5);
    rdw(BASE + 23'h2, v);
    rdw(BASE + 23'h4, v);

    // R7, R8: several patterns with a fresh readback each time
    wr(BASE + 23'hC, 16'hFFFF);
    rdw(BASE + 23'h2, v);
    wr(BASE + 23'hC, 16'h1200);
    repeat (40) @(negedge clk);
    rdw(BASE + 23'h4, v);
    wr(BASE + 23'hC, 16'h003C);
    wr(BASE + 23'h8, 16'h0000);  // R9: held until the exchange ends
    rdw(BASE + 23'h2, v);
    wr(BASE + 23'h10, 16'h0000); // lock while idle
    wr(BASE + 23'h8, 16'h8000);
    wr(BASE + 23'h10, 16'hC1AD);
    wr(BASE + 23'hC, 16'h0081);
    wr(BASE + 23'h10, 16'h0000); // R9: key write also held off

    // R3: unmapped window word and outside addresses
    wr(BASE + 23'h10, 16'hC1AD);
    rdw(BASE + 23'h6, v);
    rdw(BASE + 23'h12, v);
    rdw(23'h000100, v);
    wr(BASE + 23'h10, 16'h0000);
    rdw(BASE + 23'h2, v);
    rdw(BASE + 23'h0, v);

    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule